// File: doc/BRIEF.md
# Register-Indirect Two-Channel Bus Bridge

This block is an APB slave that lets a processor reach a slow downstream peripheral bus that cannot be mapped into its own address space. There are two downstream channels. For each channel, software stages the whole transfer in a small set of registers: an enable flag, a direction, a transfer size, a target address and the write data. A write to the trigger register then launches exactly one downstream transaction on whichever channel is enabled.

When the transaction finishes with a clean acknowledge, two things happen. A read result is latched into that channel's read-data register. A per-channel acknowledge flag is raised in an interrupt status register, and the interrupt output follows the OR of those flags. If the downstream side reports an error, or stays silent past a timeout, nothing is latched and no flag is raised.

Three byte-order configuration registers hold fixed reset patterns. The bridge only works with the big-endian patterns, so writing any other value to them is answered with an APB error.

Top module: `ibb_bridge`

## Requirements
- R1: After reset, word 0x00 reads 0x000000A1. Status word 0x48 reads 0 and `irq` is low. No `dn_req` bit is high. The byte-order words reset as follows:
  - 0x4C reads 0x0044EEE4.
  - 0x50 reads 0x0055AAFF.
  - 0x5C reads 0x0044EEE4.
- R2: A write to 0x04 launches a transaction when exactly one channel's enable bit is set and no transaction is in flight. The enable bit is bit 0 of 0x10 for channel 0 and bit 0 of 0x28 for channel 1. In the cycle after the write completes, the launch drives the following outputs:
  - `dn_req` bit c goes high for the enabled channel c.
  - `dn_we` equals the inverse of mode bit 0 (mode 1 = read, 0 = write). The mode word is 0x14 for channel 0 and 0x2C for channel 1.
  - `dn_size` equals size bits [1:0]. The byte count is that value plus one. The size word is 0x18 for channel 0 and 0x30 for channel 1.
  - `dn_addr` equals address word 0x1C (channel 0) or 0x34 (channel 1).
  - `dn_wdata` equals write-data word 0x20 (channel 0) or 0x38 (channel 1).
  - All of these hold steady while the request is pending.
- R3: A trigger written with neither channel enabled, or with both enabled, starts nothing and is answered with `pslverr`.
- R4: A trigger whose staged size has any bit above bit 1 set starts nothing, raises no acknowledge flag, and is answered with `pslverr`.
- R5: A clean acknowledge (`dn_ack` with `dn_err` low) sets status bit 16 for channel 0 or bit 17 for channel 1. For a read, it also captures `dn_rdata` of that channel into word 0x84 (channel 0) or 0x90 (channel 1).
- R6: An acknowledge with `dn_err` high, or no acknowledge within TIMEOUT cycles of the request, ends the transaction. In both cases `dn_req` drops, the read-data word is unchanged and no status bit is set.
- R7: Bit 0 of word 0x04 reads 1 while a transaction is in flight. A trigger written during that time is ignored and gives no error.
- R8: Writing 1 to status bit 16 or 17 clears it, and writing 0 leaves it unchanged. `irq` is high exactly when a status bit is set.
- R9: The byte-order words store any value written. A write to one of them that differs from its required pattern is answered with `pslverr`. The required patterns are:
  - 0x0011101B at 0x4C.
  - 0x0C330F3F at 0x50.
  - 0x00030B1B at 0x5C.
- R10: Register access is 32-bit only. A write with `pstrb` other than 4'hF is discarded and answered with `pslverr`. `pready` is always high, and unmapped words in the 4 KiB window read 0.
- R11: At most one `dn_req` bit is high at a time. A request stays high until it is acknowledged or times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address inside the 4 KiB window |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB byte strobes |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error response |
| dn_req | output | 2 | Per-channel downstream request |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_size | output | 2 | Downstream byte count minus one |
| dn_addr | output | DN_AW | Downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 2 | Per-channel downstream acknowledge |
| dn_err | input | 2 | Per-channel error, valid with acknowledge |
| dn_rdata | input | 2x32 | Per-channel downstream read data |
| irq | output | 1 | Interrupt, OR of acknowledge flags |

## Verification
The properties assume that the downstream side raises `dn_ack` only for a channel whose request is high. They also assume the acknowledge lasts a single cycle, and that `dn_err` means something only alongside it. The bench responder follows this throughout. It waits for the request to be visible, pulses the acknowledge and error bits for exactly one cycle, and never touches the idle channel. For the timeout case it simply never answers. APB accesses always run a setup phase followed by one access phase, so the error property on rejected triggers sees well-formed transfers only.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
   localparam int NCH = 2;

   localparam logic [11:0] A_VERSION  = 12'h000;
   localparam logic [11:0] A_TRIGGER  = 12'h004;
   localparam logic [11:0] A_CONTROL  = 12'h008;
   localparam logic [11:0] A_WINDOW   = 12'h00C;
   localparam logic [11:0] A_STATUS   = 12'h048;
   localparam logic [11:0] A_WBO_WORD = 12'h04C;
   localparam logic [11:0] A_WBO_BYTE = 12'h050;
   localparam logic [11:0] A_RBO      = 12'h05C;

   localparam logic [31:0] VERSION_VAL  = 32'h0000_00A1;
   localparam logic [31:0] WBO_WORD_RST = 32'h0044_EEE4;
   localparam logic [31:0] WBO_BYTE_RST = 32'h0055_AAFF;
   localparam logic [31:0] RBO_RST      = 32'h0044_EEE4;
   localparam logic [31:0] WBO_WORD_REQ = 32'h0011_101B;
   localparam logic [31:0] WBO_BYTE_REQ = 32'h0C33_0F3F;
   localparam logic [31:0] RBO_REQ      = 32'h0003_0B1B;

   localparam int ACK_LSB = 16;

   // staged-register block base and read-data word per channel
   function automatic logic [11:0] stage_base(input int c);
      return (c == 0) ? 12'h010 : 12'h028;
   endfunction
   function automatic logic [11:0] rdata_word(input int c);
      return (c == 0) ? 12'h084 : 12'h090;
   endfunction

   typedef struct packed {
      logic        en;
      logic        rd;
      logic [31:0] size;
      logic [31:0] addr;
      logic [31:0] wdata;
   } stage_t;
endpackage

// File: rtl/ibb_stage.sv
module ibb_stage
   import ibb_pkg::*;
#(
   parameter logic [11:0] BASE  = 12'h010,
   parameter logic [11:0] RDOFF = 12'h084
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [11:0] word,
   input  logic [31:0] wdata,
   input  logic        cap_en,
   input  logic [31:0] cap_data,
   output stage_t      stage,
   output logic [31:0] rd_val,
   output logic        rd_hit
);
   localparam logic [11:0] O_EN   = BASE;
   localparam logic [11:0] O_MODE = BASE + 12'h004;
   localparam logic [11:0] O_SIZE = BASE + 12'h008;
   localparam logic [11:0] O_ADDR = BASE + 12'h00C;
   localparam logic [11:0] O_WDAT = BASE + 12'h010;

   stage_t      st_q;
   logic [31:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         rdata_q <= '0;
      end else begin
         if (wr_en) begin
            case (word)
               O_EN:    st_q.en    <= wdata[0];
               O_MODE:  st_q.rd    <= wdata[0];
               O_SIZE:  st_q.size  <= wdata;
               O_ADDR:  st_q.addr  <= wdata;
               O_WDAT:  st_q.wdata <= wdata;
               default: ;
            endcase
         end
         if (cap_en) rdata_q <= cap_data;
      end
   end

   assign stage = st_q;

   always_comb begin
      rd_hit = 1'b1;
      case (word)
         O_EN:    rd_val = {31'd0, st_q.en};
         O_MODE:  rd_val = {31'd0, st_q.rd};
         O_SIZE:  rd_val = st_q.size;
         O_ADDR:  rd_val = st_q.addr;
         O_WDAT:  rd_val = st_q.wdata;
         RDOFF:   rd_val = rdata_q;
         default: begin
            rd_val = '0;
            rd_hit = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/ibb_seq.sv
module ibb_seq #(
   parameter int NCH     = 2,
   parameter int TIMEOUT = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [$clog2(NCH)-1:0] start_ch,
   input  logic [NCH-1:0]       ack,
   input  logic [NCH-1:0]       err,
   output logic [NCH-1:0]       req,
   output logic                 busy,
   output logic                 done,
   output logic                 ok,
   output logic [$clog2(NCH)-1:0] cur_ch
);
   localparam int CHW = $clog2(NCH);
   localparam int CW  = $clog2(TIMEOUT);

   if (TIMEOUT < 2) begin : g_bad_tmo
      $error("ibb_seq: TIMEOUT must be at least 2");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("ibb_seq: NCH must be at least 2");
   end

   logic           busy_q;
   logic [CHW-1:0] ch_q;
   logic [CW-1:0]  cnt_q;
   logic           tmo;

   assign tmo  = (cnt_q == CW'(TIMEOUT - 1));
   assign done = busy_q & (ack[ch_q] | tmo);
   assign ok   = busy_q & ack[ch_q] & ~err[ch_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ch_q   <= '0;
         cnt_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         ch_q   <= start_ch;
         cnt_q  <= '0;
      end else if (done) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_req
      assign req[c] = busy_q && (ch_q == CHW'(c));
   end

   assign busy   = busy_q;
   assign cur_ch = ch_q;
endmodule

// File: rtl/ibb_bridge.sv
module ibb_bridge
   import ibb_pkg::*;
#(
   parameter int TIMEOUT = 256,
   parameter int DN_AW   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             psel,
   input  logic             penable,
   input  logic             pwrite,
   input  logic [11:0]      paddr,
   input  logic [31:0]      pwdata,
   input  logic [3:0]       pstrb,
   output logic [31:0]      prdata,
   output logic             pready,
   output logic             pslverr,
   output logic [1:0]       dn_req,
   output logic             dn_we,
   output logic [1:0]       dn_size,
   output logic [DN_AW-1:0] dn_addr,
   output logic [31:0]      dn_wdata,
   input  logic [1:0]       dn_ack,
   input  logic [1:0]       dn_err,
   input  logic [1:0][31:0] dn_rdata,
   output logic             irq
);
   if (DN_AW < 1 || DN_AW > 32) begin : g_bad_aw
      $error("ibb_bridge: DN_AW must be 1..32");
   end

   logic        acc, wr_ok, busy, done, ok, cur_ch;
   logic        trig, one_en, size_bad, start, trig_err, bo_err;
   logic [11:0] word;
   stage_t      stg    [NCH];
   logic [31:0] rd_val [NCH];
   logic [NCH-1:0] rd_hit;
   stage_t      sel;
   logic [31:0] ctrl_q, win_q, wbo_word_q, wbo_byte_q, rbo_q;
   logic [1:0]  st_q, st_set, st_clr;
   logic        op_we, op_rd;
   logic [1:0]  op_size;
   logic [DN_AW-1:0] op_addr;
   logic [31:0] op_wdata;

   assign acc   = psel & penable;
   assign wr_ok = acc & pwrite & (pstrb == 4'hF);
   assign word  = {paddr[11:2], 2'b00};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ibb_stage #(.BASE(stage_base(c)), .RDOFF(rdata_word(c))) u_stage (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .word(word), .wdata(pwdata),
         .cap_en(done & ok & op_rd & (cur_ch == 1'(c))),
         .cap_data(dn_rdata[c]),
         .stage(stg[c]), .rd_val(rd_val[c]), .rd_hit(rd_hit[c]));
   end

   ibb_seq #(.NCH(NCH), .TIMEOUT(TIMEOUT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_ch(stg[1].en),
      .ack(dn_ack), .err(dn_err), .req(dn_req), .busy(busy),
      .done(done), .ok(ok), .cur_ch(cur_ch));

   // trigger qualification
   assign sel      = stg[1].en ? stg[1] : stg[0];
   assign one_en   = stg[0].en ^ stg[1].en;
   assign size_bad = |sel.size[31:2];
   assign trig     = wr_ok && (word == A_TRIGGER) && !busy;
   assign start    = trig & one_en & ~size_bad;
   assign trig_err = trig & (~one_en | size_bad);

   assign bo_err = wr_ok && (((word == A_WBO_WORD) && (pwdata != WBO_WORD_REQ)) ||
                             ((word == A_WBO_BYTE) && (pwdata != WBO_BYTE_REQ)) ||
                             ((word == A_RBO)      && (pwdata != RBO_REQ)));

   assign pslverr = acc & ((pwrite & (pstrb != 4'hF)) | trig_err | bo_err);
   assign pready  = 1'b1;

   assign st_set = (done & ok) ? (cur_ch ? 2'b10 : 2'b01) : 2'b00;
   assign st_clr = (wr_ok && word == A_STATUS) ? pwdata[ACK_LSB +: 2] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         win_q      <= '0;
         wbo_word_q <= WBO_WORD_RST;
         wbo_byte_q <= WBO_BYTE_RST;
         rbo_q      <= RBO_RST;
         st_q       <= '0;
         op_we      <= 1'b0;
         op_rd      <= 1'b0;
         op_size    <= '0;
         op_addr    <= '0;
         op_wdata   <= '0;
      end else begin
         if (wr_ok) begin
            case (word)
               A_CONTROL:  ctrl_q     <= pwdata;
               A_WINDOW:   win_q      <= pwdata;
               A_WBO_WORD: wbo_word_q <= pwdata;
               A_WBO_BYTE: wbo_byte_q <= pwdata;
               A_RBO:      rbo_q      <= pwdata;
               default: ;
            endcase
         end
         st_q <= (st_q & ~st_clr) | st_set;
         if (start) begin
            op_we    <= ~sel.rd;
            op_rd    <= sel.rd;
            op_size  <= sel.size[1:0];
            op_addr  <= sel.addr[DN_AW-1:0];
            op_wdata <= sel.wdata;
         end
      end
   end

   assign dn_we    = op_we;
   assign dn_size  = op_size;
   assign dn_addr  = op_addr;
   assign dn_wdata = op_wdata;
   assign irq      = |st_q;

   always_comb begin
      case (word)
         A_VERSION:  prdata = VERSION_VAL;
         A_TRIGGER:  prdata = {31'd0, busy};
         A_CONTROL:  prdata = ctrl_q;
         A_WINDOW:   prdata = win_q;
         A_STATUS:   prdata = {14'd0, st_q, 16'd0};
         A_WBO_WORD: prdata = wbo_word_q;
         A_WBO_BYTE: prdata = wbo_byte_q;
         A_RBO:      prdata = rbo_q;
         default: begin
            prdata = '0;
            for (int c = 0; c < NCH; c++)
               if (rd_hit[c]) prdata = rd_val[c];
         end
      endcase
   end
endmodule

// File: rtl/ibb_bridge_chk.sv
module ibb_bridge_chk #(
   parameter int TIMEOUT = 256,
   parameter int DN_AW   = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             psel,
   input logic             penable,
   input logic             pwrite,
   input logic [11:0]      paddr,
   input logic             pslverr,
   input logic [1:0]       dn_req,
   input logic [1:0]       dn_ack,
   input logic [1:0]       dn_err,
   input logic [DN_AW-1:0] dn_addr,
   input logic             irq
);
   localparam int AW = $clog2(TIMEOUT) + 2;
   logic [AW-1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       age <= '0;
      else if (|dn_req) age <= age + 1'b1;
      else              age <= '0;
   end

   assert_onehot_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dn_req));

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((|dn_req) && !(|(dn_ack & dn_req)) && (age < AW'(TIMEOUT - 1)))
      |=> (dn_req == $past(dn_req)));

   assert_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|dn_req) |-> (age < AW'(TIMEOUT)));

   assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|dn_req) |=> (!(|dn_req) || $stable(dn_addr)));

   assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|(dn_req & dn_ack & ~dn_err)));

   assert_no_launch_on_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pwrite && paddr[11:2] == 10'h001 && pslverr)
      |=> (dn_req == 2'b00));
endmodule

bind ibb_bridge ibb_bridge_chk #(.TIMEOUT(TIMEOUT), .DN_AW(DN_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pslverr(pslverr), .dn_req(dn_req), .dn_ack(dn_ack),
   .dn_err(dn_err), .dn_addr(dn_addr), .irq(irq));

// File: tb/ibb_bridge_tb.sv
module ibb_bridge_tb;
   localparam int TMO = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic psel = 0, penable = 0, pwrite = 0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [3:0]  pstrb = 4'hF;
   logic [31:0] prdata;
   logic pready, pslverr, dn_we, irq;
   logic [1:0] dn_req, dn_size;
   logic [31:0] dn_addr, dn_wdata;
   logic [1:0] dn_ack = '0, dn_err = '0;
   logic [1:0][31:0] dn_rdata = '0;
   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   ibb_bridge #(.TIMEOUT(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .dn_req(dn_req), .dn_we(dn_we),
      .dn_size(dn_size), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
      .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d,
                         output logic err, input logic [3:0] s = 4'hF);
      @(negedge clk);
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d; pstrb = s;
      @(negedge clk);
      penable = 1;
      #1 err = pslverr;
      @(negedge clk);
      psel = 0; penable = 0; pstrb = 4'hF;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(negedge clk);
      penable = 1;
      #1 d = prdata;
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   task automatic respond(input int ch, input int dly, input logic e, input logic [31:0] d);
      repeat (dly) @(negedge clk);
      dn_ack[ch] = 1; dn_err[ch] = e; dn_rdata[ch] = d;
      @(negedge clk);
      dn_ack = '0; dn_err = '0;
   endtask

   task automatic stage(input int ch, input logic rd, input logic [31:0] sz,
                        input logic [31:0] a, input logic [31:0] wd);
      logic e;
      logic [11:0] b;
      b = (ch == 0) ? 12'h010 : 12'h028;
      apb_wr(12'h010, (ch == 0) ? 32'd1 : 32'd0, e);
      apb_wr(12'h028, (ch == 1) ? 32'd1 : 32'd0, e);
      apb_wr(b + 12'h4, {31'd0, rd}, e);
      apb_wr(b + 12'h8, sz, e);
      apb_wr(b + 12'hC, a, e);
      apb_wr(b + 12'h10, wd, e);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      apb_rd(12'h000, d); chk("R1 version", d, 32'hA1);
      apb_rd(12'h048, d); chk("R1 status", d, 0);
      apb_rd(12'h04C, d); chk("R1 wbo word", d, 32'h0044EEE4);
      apb_rd(12'h050, d); chk("R1 wbo byte", d, 32'h0055AAFF);
      apb_rd(12'h05C, d); chk("R1 rbo", d, 32'h0044EEE4);
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 req", {30'd0, dn_req}, 0);
      chk("R10 pready", {31'd0, pready}, 1);
      apb_rd(12'h200, d); chk("R10 unmapped", d, 0);
   endtask

   task automatic t_ch0_write();
      logic e; logic [31:0] d;
      stage(0, 0, 32'd3, 32'h8000_1234, 32'hA5A5_0F0F);
      apb_wr(12'h004, 0, e);
      chk("R2 trig err", {31'd0, e}, 0);
      chk("R2 req ch0", {30'd0, dn_req}, 32'h1);
      chk("R2 we", {31'd0, dn_we}, 1);
      chk("R2 size", {30'd0, dn_size}, 3);
      chk("R2 addr", dn_addr, 32'h8000_1234);
      chk("R2 wdata", dn_wdata, 32'hA5A5_0F0F);
      apb_rd(12'h004, d); chk("R7 busy", d, 1);
      chk("R11 req held", {30'd0, dn_req}, 32'h1);
      respond(0, 1, 0, 0);
      chk("R11 req drop", {30'd0, dn_req}, 0);
      apb_rd(12'h048, d); chk("R5 ack ch0", d, 32'h0001_0000);
      chk("R8 irq set", {31'd0, irq}, 1);
      apb_wr(12'h048, 32'h0002_0000, e);
      apb_rd(12'h048, d); chk("R8 w1c zero keep", d, 32'h0001_0000);
      apb_wr(12'h048, 32'h0001_0000, e);
      apb_rd(12'h048, d); chk("R8 w1c clear", d, 0);
      chk("R8 irq clear", {31'd0, irq}, 0);
   endtask

   task automatic t_ch1_read();
      logic e; logic [31:0] d;
      stage(1, 1, 32'd1, 32'h0000_0040, 0);
      apb_wr(12'h004, 0, e);
      chk("R2 req ch1", {30'd0, dn_req}, 32'h2);
      chk("R2 read dir", {31'd0, dn_we}, 0);
      chk("R2 half size", {30'd0, dn_size}, 1);
      respond(1, 2, 0, 32'hCAFE_1234);
      apb_rd(12'h090, d); chk("R5 rdata ch1", d, 32'hCAFE_1234);
      apb_rd(12'h084, d); chk("R5 rdata ch0 untouched", d, 0);
      apb_rd(12'h048, d); chk("R5 ack ch1", d, 32'h0002_0000);
      apb_wr(12'h048, 32'h0003_0000, e);
   endtask

   task automatic t_err_resp();
      logic e; logic [31:0] d;
      apb_wr(12'h004, 0, e);
      respond(1, 0, 1, 32'hDEAD_0000);
      apb_rd(12'h090, d); chk("R6 err keeps rdata", d, 32'hCAFE_1234);
      apb_rd(12'h048, d); chk("R6 err no ack", d, 0);
      chk("R6 err irq", {31'd0, irq}, 0);
   endtask

   task automatic t_timeout();
      logic e; logic [31:0] d;
      apb_wr(12'h004, 0, e);
      chk("R6 tmo req up", {30'd0, dn_req}, 32'h2);
      repeat (TMO + 2) @(negedge clk);
      chk("R6 tmo req drop", {30'd0, dn_req}, 0);
      apb_rd(12'h004, d); chk("R6 tmo idle", d, 0);
      apb_rd(12'h048, d); chk("R6 tmo no ack", d, 0);
   endtask

   task automatic t_bad_trig();
      logic e; logic [31:0] d;
      apb_wr(12'h028, 0, e);
      apb_wr(12'h004, 0, e);
      chk("R3 none err", {31'd0, e}, 1);
      chk("R3 none req", {30'd0, dn_req}, 0);
      apb_wr(12'h010, 1, e);
      apb_wr(12'h028, 1, e);
      apb_wr(12'h004, 0, e);
      chk("R3 both err", {31'd0, e}, 1);
      chk("R3 both req", {30'd0, dn_req}, 0);
      stage(0, 0, 32'd4, 32'h10, 32'h20);
      apb_wr(12'h004, 0, e);
      chk("R4 size err", {31'd0, e}, 1);
      chk("R4 size req", {30'd0, dn_req}, 0);
      apb_rd(12'h048, d); chk("R4 no ack", d, 0);
   endtask

   task automatic t_busy_trig();
      logic e;
      stage(0, 0, 32'd0, 32'h77, 32'h99);
      apb_wr(12'h004, 0, e);
      apb_wr(12'h004, 0, e);
      chk("R7 busy trig no err", {31'd0, e}, 0);
      chk("R7 req kept", {30'd0, dn_req}, 32'h1);
      respond(0, 0, 0, 0);
      @(negedge clk);
      chk("R7 no relaunch", {30'd0, dn_req}, 0);
      apb_wr(12'h048, 32'h0003_0000, e);
   endtask

   task automatic t_byte_order();
      logic e; logic [31:0] d;
      apb_wr(12'h04C, 32'h1234_5678, e);
      chk("R9 bad pattern err", {31'd0, e}, 1);
      apb_rd(12'h04C, d); chk("R9 bad stored", d, 32'h1234_5678);
      apb_wr(12'h04C, 32'h0011101B, e); chk("R9 word ok", {31'd0, e}, 0);
      apb_wr(12'h050, 32'h0C330F3F, e); chk("R9 byte ok", {31'd0, e}, 0);
      apb_wr(12'h05C, 32'h00030B1B, e); chk("R9 read ok", {31'd0, e}, 0);
      apb_rd(12'h05C, d); chk("R9 read stored", d, 32'h00030B1B);
   endtask

   task automatic t_strobe();
      logic e; logic [31:0] d;
      apb_wr(12'h01C, 32'h5555_AAAA, e, 4'h3);
      chk("R10 strobe err", {31'd0, e}, 1);
      apb_rd(12'h01C, d); chk("R10 strobe discard", d, 32'h77);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_ch0_write();
      t_ch1_read();
      t_err_resp();
      t_timeout();
      t_bad_trig();
      t_busy_trig();
      t_byte_order();
      t_strobe();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule